// File: doc/BRIEF.md
# Configurable Nine-Tap Convolution Datapath

This block is a synchronous multiply-accumulate engine that weights nine 8-bit samples with nine 8-bit coefficients. Every clock it produces one 20-bit sum of products. That width holds the largest possible sum, so the result never overflows.

The block has two modes.
- **Two-dimensional:** three row buses carry one image line each, oldest to newest. Two column delays per row build a 3x3 neighbourhood.
- **One-dimensional:** only the newest-row bus is used. The nine delay stages are chained into a single 9-tap FIR line.

A 4-bit configuration word selects the mode, the number format (unsigned or two's complement) and an optional output rounding to 16 or 8 significant bits. The coefficients arrive as one parallel 72-bit word.

Two inputs control the pipeline.
- **Hold:** a synchronous input, registered once. It freezes every delay, pipeline and output register from the cycle after it is seen.
- **Frame reset:** an asynchronous, active-low input. It clears all pipeline state between frames. The coefficient and configuration inputs need no reload.

Top module: `tap9_conv`

## Requirements
- R1: While `frameN` is low, `resultOut` reads 0, and it is still 0 at the first rising edge after release.
- R2: With `cfgWord[1]`=0 (1-D), result(n) = A·x(n-8) + B·x(n-7) + … + H·x(n-1) + I·x(n), where x is `rowNew`. Coefficient A sits in `coefs[7:0]` and coefficient I in `coefs[71:64]`. `rowMid` and `rowOld` have no effect.
- R3: With `cfgWord[1]`=1 (2-D), `rowOld` is weighted by A,B,C, `rowMid` by D,E,F and `rowNew` by G,H,I. In each row the first coefficient of the three multiplies the sample taken two clocks earlier, the middle one the sample taken one clock earlier, and the last one the newest sample.
- R4: `cfgWord[0]`=0 treats both samples and coefficients as unsigned. `cfgWord[0]`=1 treats both as two's complement. The 20-bit result is exact in either format, including the extremes 9·255·255 and 9·(-128)·(-128).
- R5: `cfgWord[3:2]`=01 adds 8 to the full sum and clears bits 3:0, keeping bits 19:4 rounded.
- R6: `cfgWord[3:2]`=10 adds 2048 to the full sum and clears bits 11:0, keeping bits 19:12 rounded.
- R7: `cfgWord[3:2]`=00 gives the exact sum. Encoding 11 behaves exactly like 00.
- R8: A sample captured at rising edge t contributes to `resultOut` from edge t+2, the first output register update that can include it.
- R9: `holdIn` high at edge k leaves every register unchanged at edge k+1. Samples presented for such a frozen edge are discarded, and `resultOut` keeps its value.
- R10: After a frame reset, the result depends only on samples captured after release. Samples from before the reset contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| frameN | input | 1 | Asynchronous active-low frame reset of all pipeline state |
| holdIn | input | 1 | Freeze request, effective one cycle after it is sampled |
| cfgWord | input | 4 | [0] format, [1] mode, [3:2] rounding select |
| coefs | input | 72 | Nine coefficients, A in [7:0] up to I in [71:64] |
| rowNew | input | 8 | Newest row (2-D) or the only sample stream (1-D) |
| rowMid | input | 8 | Middle row (2-D only) |
| rowOld | input | 8 | Oldest row (2-D only) |
| resultOut | output | 20 | Registered, optionally rounded sum of products |

## Verification
The bench builds the block with its default widths: 8-bit samples and coefficients and a 20-bit result. Those are the widths at which the unsigned and signed extremes exactly reach the limits of the result. They are also the widths at which the two rounding points fall on bits 4 and 12. A software model replays every captured sample through both modes, both formats and all four rounding codes. It also follows frozen edges, so hold bursts in either mode line up cycle by cycle. An impulse stream exposes the two-clock latency and the coefficient order. A frame reset directly after a full-scale run shows that no history survives.

// File: rtl/tap9_pkg.sv
package tap9_pkg;

  localparam int CFG_FMT_BIT  = 0;
  localparam int CFG_MODE_BIT = 1;
  localparam int CFG_RND_LO   = 2;
  localparam int CFG_W        = 4;

  typedef enum logic [1:0] {
    RND_NONE = 2'b00,
    RND_16   = 2'b01,
    RND_8    = 2'b10,
    RND_BAD  = 2'b11
  } tap9_round_e;

  typedef struct packed {
    logic        advance;
    logic        signedMode;
    logic        twoD;
    tap9_round_e roundSel;
  } tap9_ctrl_t;

endpackage

// File: rtl/tap9_ctrl.sv
module tap9_ctrl
  import tap9_pkg::*;
(
  input  logic             clk,
  input  logic             frameN,
  input  logic             holdIn,
  input  logic [CFG_W-1:0] cfgWord,
  output tap9_ctrl_t       ctl
);

  logic holdQ;
  logic [1:0] rndRaw;

  // Hold is registered once, so a request seen at one edge freezes the next.
  always_ff @(posedge clk or negedge frameN) begin
    if (!frameN) holdQ <= 1'b0;
    else         holdQ <= holdIn;
  end

  assign rndRaw = cfgWord[CFG_RND_LO +: 2];

  always_comb begin
    ctl.advance    = ~holdQ;
    ctl.signedMode = cfgWord[CFG_FMT_BIT];
    ctl.twoD       = cfgWord[CFG_MODE_BIT];
    ctl.roundSel   = (rndRaw == RND_BAD) ? RND_NONE : tap9_round_e'(rndRaw);
  end

endmodule

// File: rtl/tap9_datapath.sv
module tap9_datapath
  import tap9_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int RESULT_W = 20
) (
  input  logic                  clk,
  input  logic                  frameN,
  input  tap9_ctrl_t            ctl,
  input  logic [SAMPLE_W-1:0]   rowNew,
  input  logic [SAMPLE_W-1:0]   rowMid,
  input  logic [SAMPLE_W-1:0]   rowOld,
  input  logic [9*COEF_W-1:0]   coefs,
  output logic [RESULT_W-1:0]   resultOut
);

  localparam int ROWS   = 3;
  localparam int COLS   = 3;
  localparam int TAPS   = ROWS * COLS;
  localparam int PROD_W = (SAMPLE_W + 1) + (COEF_W + 1);
  localparam int DROP16 = RESULT_W - 16;
  localparam int DROP8  = RESULT_W - 8;
  localparam logic [RESULT_W-1:0] HALF16 = RESULT_W'(1) << (DROP16 - 1);
  localparam logic [RESULT_W-1:0] HALF8  = RESULT_W'(1) << (DROP8 - 1);
  localparam logic [RESULT_W-1:0] MASK16 = ~((RESULT_W'(1) << DROP16) - RESULT_W'(1));
  localparam logic [RESULT_W-1:0] MASK8  = ~((RESULT_W'(1) << DROP8) - RESULT_W'(1));

  logic [SAMPLE_W-1:0]      rowBus [ROWS];
  logic [SAMPLE_W-1:0]      entry  [ROWS];
  logic [SAMPLE_W-1:0]      win    [TAPS];
  logic signed [PROD_W-1:0] prodD  [TAPS];
  logic signed [PROD_W-1:0] prodQ  [TAPS];
  logic [RESULT_W-1:0]      accSum;
  logic [RESULT_W-1:0]      rounded;

  // Row 0 is the oldest line (A,B,C), the last row the newest (G,H,I).
  assign rowBus[0]      = rowOld;
  assign rowBus[1]      = rowMid;
  assign rowBus[ROWS-1] = rowNew;

  // Row entry: in 1-D the rows chain into one nine-stage line fed by rowNew.
  for (genvar r = 0; r < ROWS; r++) begin : g_entry
    if (r == ROWS - 1) begin : g_last
      assign entry[r] = rowBus[r];
    end else begin : g_chain
      assign entry[r] = ctl.twoD ? rowBus[r] : win[(r + 1) * COLS];
    end
  end

  // Window: index r*COLS+c lines up with coefficient r*COLS+c;
  // column COLS-1 holds the newest sample, column 0 the oldest.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [SAMPLE_W-1:0] nextVal;
      if (c == COLS - 1) begin : g_in
        assign nextVal = entry[r];
      end else begin : g_sh
        assign nextVal = win[r * COLS + c + 1];
      end
      always_ff @(posedge clk or negedge frameN) begin
        if (!frameN)          win[r * COLS + c] <= '0;
        else if (ctl.advance) win[r * COLS + c] <= nextVal;
      end
    end
  end

  // Multipliers: operands widened by one bit, signed or zero extended.
  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    logic [COEF_W-1:0]          coefK;
    logic signed [SAMPLE_W:0]   sExt;
    logic signed [COEF_W:0]     cExt;
    assign coefK    = coefs[k * COEF_W +: COEF_W];
    assign sExt     = {ctl.signedMode & win[k][SAMPLE_W-1], win[k]};
    assign cExt     = {ctl.signedMode & coefK[COEF_W-1], coefK};
    assign prodD[k] = sExt * cExt;

    always_ff @(posedge clk or negedge frameN) begin
      if (!frameN)          prodQ[k] <= '0;
      else if (ctl.advance) prodQ[k] <= prodD[k];
    end
  end

  always_comb begin
    accSum = '0;
    for (int k = 0; k < TAPS; k++) begin
      accSum = accSum + RESULT_W'(prodQ[k]);
    end
  end

  always_comb begin
    unique case (ctl.roundSel)
      RND_16:  rounded = (accSum + HALF16) & MASK16;
      RND_8:   rounded = (accSum + HALF8) & MASK8;
      default: rounded = accSum;
    endcase
  end

  always_ff @(posedge clk or negedge frameN) begin
    if (!frameN)          resultOut <= '0;
    else if (ctl.advance) resultOut <= rounded;
  end

endmodule

// File: rtl/tap9_conv.sv
module tap9_conv
  import tap9_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int RESULT_W = 20
) (
  input  logic                clk,
  input  logic                frameN,
  input  logic                holdIn,
  input  logic [CFG_W-1:0]    cfgWord,
  input  logic [9*COEF_W-1:0] coefs,
  input  logic [SAMPLE_W-1:0] rowNew,
  input  logic [SAMPLE_W-1:0] rowMid,
  input  logic [SAMPLE_W-1:0] rowOld,
  output logic [RESULT_W-1:0] resultOut
);

  tap9_ctrl_t ctl;

  tap9_ctrl u_ctrl (
    .clk     (clk),
    .frameN  (frameN),
    .holdIn  (holdIn),
    .cfgWord (cfgWord),
    .ctl     (ctl)
  );

  tap9_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .RESULT_W (RESULT_W)
  ) u_dp (
    .clk       (clk),
    .frameN    (frameN),
    .ctl       (ctl),
    .rowNew    (rowNew),
    .rowMid    (rowMid),
    .rowOld    (rowOld),
    .coefs     (coefs),
    .resultOut (resultOut)
  );

endmodule

// File: rtl/tap9_conv_chk.sv
module tap9_conv_chk
  import tap9_pkg::*;
#(
  parameter int RESULT_W = 20
) (
  input logic                clk,
  input logic                frameN,
  input logic                holdIn,
  input logic [CFG_W-1:0]    cfgWord,
  input logic [RESULT_W-1:0] resultOut,
  input tap9_ctrl_t          ctl
);

  // Set once an edge has passed with the frame reset released, so that
  // $past never reaches back into reset.
  logic armed;
  always_ff @(posedge clk or negedge frameN) begin
    if (!frameN) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R9: the control strobe follows holdIn with exactly one cycle of delay.
  p_hold_strobe_r9: assert property (@(posedge clk) disable iff (!frameN)
    armed |-> (ctl.advance == !$past(holdIn)));

  // R9: an edge after holdIn was seen high leaves the output unchanged.
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!frameN)
    (armed && $past(holdIn)) |=> $stable(resultOut));

  // R5: an output written under 16-bit rounding has its four low bits clear.
  p_round16_r5: assert property (@(posedge clk) disable iff (!frameN)
    (armed && $past(ctl.advance) && ($past(cfgWord[3:2]) == 2'b01))
      |-> (resultOut[3:0] == 4'd0));

  // R6: an output written under 8-bit rounding has its twelve low bits clear.
  p_round8_r6: assert property (@(posedge clk) disable iff (!frameN)
    (armed && $past(ctl.advance) && ($past(cfgWord[3:2]) == 2'b10))
      |-> (resultOut[11:0] == 12'd0));

endmodule

bind tap9_conv tap9_conv_chk #(.RESULT_W(RESULT_W)) u_chk (
  .clk       (clk),
  .frameN    (frameN),
  .holdIn    (holdIn),
  .cfgWord   (cfgWord),
  .resultOut (resultOut),
  .ctl       (ctl)
);

// File: tb/sim_tap9_conv.sv
`timescale 1ns/1ps
module sim_tap9_conv;

  logic        clk = 1'b0;
  logic        frameN = 1'b0;
  logic        holdIn = 1'b0;
  logic [3:0]  cfgWord = 4'd0;
  logic [71:0] coefs = '0;
  logic [7:0]  rowNew = 8'd0, rowMid = 8'd0, rowOld = 8'd0;
  logic [19:0] resultOut;

  int nChecks = 0;
  int nFail   = 0;

  logic [7:0] cf [9];
  logic [7:0] s1 [64];
  logic [7:0] s2 [64];
  logic [7:0] s3 [64];

  always #10 clk = ~clk;

  tap9_conv u0 (
    .clk(clk), .frameN(frameN), .holdIn(holdIn), .cfgWord(cfgWord),
    .coefs(coefs), .rowNew(rowNew), .rowMid(rowMid), .rowOld(rowOld),
    .resultOut(resultOut)
  );

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int ext(input logic [7:0] v, input bit sgn);
    return sgn ? int'($signed(v)) : int'(v);
  endfunction

  function automatic logic [7:0] pat(input int kind, input int bus, input int idx, input int seed);
    case (kind)
      1: return 8'd255;
      2: return 8'd128;
      3: return (idx % 2 == 1) ? 8'd255 : 8'd3;
      4: return (bus == 1 && idx == 0) ? 8'd1 : 8'd0;
      default: return 8'((idx * 53 + bus * 101 + seed * 29 + idx * idx * 7) & 255);
    endcase
  endfunction

  // Expected result after an update that used the window holding samples up to m.
  function automatic logic [19:0] model(input int m);
    int sum = 0;
    bit sg = cfgWord[0];
    logic [31:0] t;
    if (m < 0) return 20'd0;
    if (!cfgWord[1]) begin
      for (int k = 0; k < 9; k++) begin
        int idx = m - (8 - k);
        if (idx >= 0) sum += ext(cf[k], sg) * ext(s1[idx], sg);
      end
    end else begin
      for (int r = 0; r < 3; r++) begin
        for (int c = 0; c < 3; c++) begin
          int idx = m - (2 - c);
          logic [7:0] v;
          if (idx >= 0) begin
            v = (r == 0) ? s3[idx] : (r == 1) ? s2[idx] : s1[idx];
            sum += ext(cf[r * 3 + c], sg) * ext(v, sg);
          end
        end
      end
    end
    if (cfgWord[3:2] == 2'b01) sum = (sum + 8) & ~15;
    else if (cfgWord[3:2] == 2'b10) sum = (sum + 2048) & ~4095;
    t = sum;
    return t[19:0];
  endfunction

  task automatic setCoefs(input int c0, input int c1, input int c2, input int c3,
                          input int c4, input int c5, input int c6, input int c7, input int c8);
    cf[0] = 8'(c0); cf[1] = 8'(c1); cf[2] = 8'(c2); cf[3] = 8'(c3); cf[4] = 8'(c4);
    cf[5] = 8'(c5); cf[6] = 8'(c6); cf[7] = 8'(c7); cf[8] = 8'(c8);
    for (int k = 0; k < 9; k++) coefs[k * 8 +: 8] = cf[k];
  endtask

  // One scenario: frame reset, then a stream of n samples with an optional hold burst.
  task automatic runCase(input string req, input logic [3:0] cfg, input int n,
                         input int kind, input int seed, input int hStart, input int hLen);
    int captured = 0;
    bit holdPrev = 0;
    logic [19:0] prevOut = 20'd0;
    logic [19:0] exp;
    logic [7:0] p1, p2, p3;
    cfgWord = cfg;
    holdIn = 1'b0;
    frameN = 1'b0;
    rowNew = 8'h5A; rowMid = 8'hC3; rowOld = 8'h77;
    #3 check("R1", resultOut, 20'd0);
    @(negedge clk);
    check("R1", resultOut, 20'd0);
    frameN = 1'b1;
    p1 = pat(kind, 1, 0, seed); p2 = pat(kind, 2, 0, seed); p3 = pat(kind, 3, 0, seed);
    rowNew = p1; rowMid = p2; rowOld = p3;
    holdIn = (hLen > 0 && hStart == 0);
    for (int j = 0; j < n + 3 + hLen; j++) begin
      bit frozen;
      @(posedge clk);
      frozen = holdPrev;
      holdPrev = holdIn;
      if (!frozen) begin
        s1[captured] = p1; s2[captured] = p2; s3[captured] = p3;
        exp = model(captured - 2);
        captured++;
      end else begin
        exp = prevOut;
      end
      @(negedge clk);
      check(req, resultOut, exp);
      if (j == 0 && req != "R8") check("R1", resultOut, 20'd0);
      prevOut = exp;
      holdIn = (hLen > 0 && (j + 1) >= hStart && (j + 1) < hStart + hLen);
      if (holdPrev) begin
        p1 = 8'hE7; p2 = 8'h19; p3 = 8'hB2;
      end else if (captured < n) begin
        p1 = pat(kind, 1, captured, seed);
        p2 = pat(kind, 2, captured, seed);
        p3 = pat(kind, 3, captured, seed);
      end else begin
        p1 = 8'd0; p2 = 8'd0; p3 = 8'd0;
      end
      rowNew = p1; rowMid = p2; rowOld = p3;
    end
  endtask

  task automatic testOneD();
    setCoefs(3, 250, 17, 0, 99, 1, 200, 45, 7);
    runCase("R2", 4'b0000, 24, 0, 1, 0, 0);
  endtask

  task automatic testTwoD();
    setCoefs(1, 2, 3, 40, 50, 60, 7, 8, 9);
    runCase("R3", 4'b0010, 24, 0, 2, 0, 0);
  endtask

  task automatic testSigned();
    setCoefs(-1, -2, -1, 0, 0, 0, 1, 2, 1);
    runCase("R4", 4'b0011, 20, 0, 3, 0, 0);
    setCoefs(-128, -128, -128, -128, -128, -128, -128, -128, -128);
    runCase("R4", 4'b0001, 16, 2, 0, 0, 0);
    setCoefs(127, -128, 127, -128, 127, -128, 127, -128, 127);
    runCase("R4", 4'b0001, 16, 3, 0, 0, 0);
  endtask

  task automatic testUnsignedMax();
    setCoefs(255, 255, 255, 255, 255, 255, 255, 255, 255);
    runCase("R4", 4'b0010, 12, 1, 0, 0, 0);
  endtask

  task automatic testFrameClear();
    setCoefs(11, 22, 33, 44, 55, 66, 77, 88, 99);
    runCase("R10", 4'b0010, 14, 1, 0, 0, 0);
    runCase("R10", 4'b0010, 10, 0, 7, 0, 0);
  endtask

  task automatic testRounding();
    setCoefs(-37, 91, 12, -5, 127, 63, -100, 44, 8);
    runCase("R5", 4'b0111, 20, 0, 4, 0, 0);
    setCoefs(200, 150, 100, 250, 30, 60, 90, 120, 180);
    runCase("R6", 4'b1010, 20, 0, 5, 0, 0);
    runCase("R6", 4'b1001, 20, 0, 8, 0, 0);
    runCase("R7", 4'b1110, 20, 0, 6, 0, 0);
    runCase("R7", 4'b0000, 20, 0, 6, 0, 0);
  endtask

  task automatic testLatency();
    setCoefs(1, 2, 3, 4, 5, 6, 7, 8, 9);
    runCase("R8", 4'b0000, 12, 4, 0, 0, 0);
    runCase("R8", 4'b0010, 8, 4, 0, 0, 0);
  endtask

  task automatic testHold();
    setCoefs(5, 9, 13, 2, 4, 6, 250, 1, 77);
    runCase("R9", 4'b0010, 20, 0, 9, 6, 3);
    runCase("R9", 4'b0000, 20, 0, 10, 9, 1);
    runCase("R9", 4'b0101, 20, 0, 11, 4, 5);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin s1[k] = 0; s2[k] = 0; s3[k] = 0; end
    for (int k = 0; k < 9; k++) cf[k] = 0;
    repeat (2) @(negedge clk);
    testOneD();
    testTwoD();
    testSigned();
    testUnsignedMax();
    testFrameClear();
    testRounding();
    testLatency();
    testHold();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule